// File: doc/BRIEF.md
# Fetch stream address controller

This block sits at the head of a pipelined instruction fetch front end and decides which address to fetch next and how many bytes to ask for. It keeps the fetch PC, a stream number, a prediction number and a per-fetch line number. A three-state control machine selects between a halted state, in which the PC is invalid, an idle state that waits for a new PC, and a running state, in which one fetch request goes out on every cycle that the downstream request tracker reports room.

The execute stage can redirect fetch to a new PC, or tell it to halt. The decode stage can redirect fetch to a predicted target. Each issued fetch carries the stream and prediction numbers that were current when it left, so a later stage can drop stale lines by comparing tags, and no flush is needed. The byte length of each fetch is cut so that it stays inside one aligned snap block and is never more than a set maximum width. For this reason the first fetch after a redirect to an unaligned PC is short, and the fetches after it fall into alignment. The block reports that it has drained once it is halted and the tracker reports that no fetch is still in flight.

Top module: `fetch_stream_ctl`

## Requirements
- R1: After reset the controller is in the waiting state. req_valid is 0, drained is 0, and the PC, stream, prediction and line numbers are all 0.
- R2: req_valid is 1 exactly when the controller is running and can_issue is 1. In the waiting and halted states no fetch is issued.
- R3: req_len equals min(MAX_W, SNAP - (req_addr mod SNAP)). A fetch therefore never crosses an aligned SNAP-byte block and never exceeds MAX_W bytes. SNAP and MAX_W are powers of two, with MAX_W no larger than SNAP.
- R4: After a fetch is issued, and no redirect is taken in the same cycle, the next req_addr is the old req_addr plus the old req_len, modulo 2^ADDR_W.
- R5: An execute redirect (exe_valid=1, exe_halt=0) is accepted in any state. From the next cycle the PC is exe_target, both the stream and prediction numbers have gone up by one, and the controller is running.
- R6: A decode redirect (dec_valid=1) that arrives while the controller is not halted sets the PC to dec_target and raises the prediction number by one. The stream number does not change, and the controller is running.
- R7: When execute and decode redirects arrive in the same cycle, only the execute redirect takes effect.
- R8: An execute redirect with exe_halt=1 moves the controller to halted. It still raises both the stream and prediction numbers by one. A decode redirect that arrives while halted is ignored: the PC and tags stay unchanged and the state stays halted.
- R9: req_line goes up by one, wrapping, for every issued fetch, and does not change otherwise.
- R10: drained is 1 exactly when the controller is halted and inflight_empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exe_valid | input | 1 | Execute-stage redirect present |
| exe_halt | input | 1 | Redirect asks fetch to halt |
| exe_target | input | ADDR_W | Execute redirect PC |
| dec_valid | input | 1 | Decode-stage predicted redirect present |
| dec_target | input | ADDR_W | Predicted target PC |
| can_issue | input | 1 | Request tracker can accept a fetch |
| inflight_empty | input | 1 | No fetch is outstanding in the tracker |
| req_valid | output | 1 | Fetch request issued this cycle |
| req_addr | output | ADDR_W | Fetch start address (current PC) |
| req_len | output | LEN_W | Fetch length in bytes |
| req_stream | output | SEQ_W | Stream tag |
| req_pred | output | SEQ_W | Prediction tag |
| req_line | output | LINE_W | Line sequence tag |
| drained | output | 1 | Halted with nothing in flight |

## Verification
Every output is decoded combinationally from registers. A redirect or an issue applied before a rising edge therefore shows up on req_addr, req_len, the tags and req_valid in that same edge's cycle, one clock after the stimulus. req_valid and drained also follow can_issue and inflight_empty inside the current cycle. The bench drives inputs just after a falling edge. At each falling edge it advances a behavioural model by the edge that has just passed and compares all outputs, so each result is checked exactly one edge after its cause. Directed steps cover the unaligned first fetch, simultaneous redirects and the halted state, and a long random run follows them.

// File: rtl/fsac_pkg.sv
package fsac_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_HALT = 2'd1,
    ST_RUN  = 2'd2
  } fstate_t;
endpackage

// File: rtl/fsac_ctrl.sv
module fsac_ctrl
  import fsac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exe_valid,
  input  logic exe_halt,
  input  logic dec_valid,
  input  logic can_issue,
  input  logic inflight_empty,
  output logic exe_take,
  output logic dec_take,
  output logic issue,
  output logic drained
);
  fstate_t state_q, state_d;

  // Execute redirects are always taken; decode ones lose to execute and are dropped while halted
  assign exe_take = exe_valid;
  assign dec_take = dec_valid && !exe_valid && (state_q != ST_HALT);
  assign issue    = (state_q == ST_RUN) && can_issue;
  assign drained  = (state_q == ST_HALT) && inflight_empty;

  always_comb begin
    state_d = state_q;
    if (exe_take)      state_d = exe_halt ? ST_HALT : ST_RUN;
    else if (dec_take) state_d = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_WAIT;
    else        state_q <= state_d;
  end

  assert_halt_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && exe_halt) |=> (!issue && (drained == inflight_empty)));
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drained && !exe_valid) |=> (drained == inflight_empty));
  assert_no_issue_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> !issue);
  assert_exe_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && dec_valid) |-> !dec_take);
endmodule

// File: rtl/fsac_seq.sv
module fsac_seq #(
  parameter int SEQ_W  = 8,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exe_take,
  input  logic              dec_take,
  input  logic              issue,
  output logic [SEQ_W-1:0]  stream_q,
  output logic [SEQ_W-1:0]  pred_q,
  output logic [LINE_W-1:0] line_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stream_q <= '0;
      pred_q   <= '0;
      line_q   <= '0;
    end else begin
      if (exe_take)             stream_q <= stream_q + SEQ_W'(1);
      if (exe_take || dec_take) pred_q   <= pred_q + SEQ_W'(1);
      if (issue)                line_q   <= line_q + LINE_W'(1);
    end
  end

  assert_stream_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !exe_take |=> $stable(stream_q));
  assert_pred_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_take || dec_take) |=> (pred_q == $past(pred_q) + SEQ_W'(1)));
  assert_line_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (line_q == $past(line_q) + LINE_W'(1)));
  assert_line_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(line_q));
endmodule

// File: rtl/fsac_pc.sv
module fsac_pc #(
  parameter int ADDR_W = 32,
  parameter int SNAP   = 64,
  parameter int MAX_W  = 16,
  parameter int LEN_W  = $clog2(MAX_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exe_take,
  input  logic [ADDR_W-1:0] exe_target,
  input  logic              dec_take,
  input  logic [ADDR_W-1:0] dec_target,
  input  logic              issue,
  output logic [ADDR_W-1:0] pc_q,
  output logic [LEN_W-1:0]  len
);
  localparam int OFF_W = $clog2(SNAP);

  // Bytes from the address to the end of its snap block, capped at the maximum width
  function automatic logic [LEN_W-1:0] clip_len(input logic [ADDR_W-1:0] a);
    logic [OFF_W:0] room;
    room = (OFF_W+1)'(SNAP) - {1'b0, a[OFF_W-1:0]};
    if (room > (OFF_W+1)'(MAX_W)) return LEN_W'(MAX_W);
    else                          return room[LEN_W-1:0];
  endfunction

  assign len = clip_len(pc_q);

  always_ff @(posedge clk) begin
    if (!rst_n)        pc_q <= '0;
    else if (exe_take) pc_q <= exe_target;
    else if (dec_take) pc_q <= dec_target;
    else if (issue)    pc_q <= pc_q + ADDR_W'(len);
  end

  assert_len_in_snap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ((len != '0) && (len <= LEN_W'(MAX_W)) &&
               ((ADDR_W+1)'(pc_q % SNAP) + (ADDR_W+1)'(len) <= (ADDR_W+1)'(SNAP))));
  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !exe_take && !dec_take) |=> (pc_q == $past(pc_q) + ADDR_W'($past(len))));
  assert_exe_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exe_take |=> (pc_q == $past(exe_target)));
  assert_dec_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_take |=> (pc_q == $past(dec_target)));
endmodule

// File: rtl/fetch_stream_ctl.sv
module fetch_stream_ctl #(
  parameter int ADDR_W = 32,
  parameter int SNAP   = 64,
  parameter int MAX_W  = 16,
  parameter int SEQ_W  = 8,
  parameter int LINE_W = 16,
  parameter int LEN_W  = $clog2(MAX_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exe_valid,
  input  logic              exe_halt,
  input  logic [ADDR_W-1:0] exe_target,
  input  logic              dec_valid,
  input  logic [ADDR_W-1:0] dec_target,
  input  logic              can_issue,
  input  logic              inflight_empty,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [SEQ_W-1:0]  req_stream,
  output logic [SEQ_W-1:0]  req_pred,
  output logic [LINE_W-1:0] req_line,
  output logic              drained
);
  // Named internal events shared by the submodules and their assertions
  logic exe_take, dec_take, issue;

  fsac_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .exe_valid(exe_valid), .exe_halt(exe_halt), .dec_valid(dec_valid),
    .can_issue(can_issue), .inflight_empty(inflight_empty),
    .exe_take(exe_take), .dec_take(dec_take), .issue(issue), .drained(drained)
  );

  fsac_seq #(.SEQ_W(SEQ_W), .LINE_W(LINE_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .exe_take(exe_take), .dec_take(dec_take), .issue(issue),
    .stream_q(req_stream), .pred_q(req_pred), .line_q(req_line)
  );

  fsac_pc #(.ADDR_W(ADDR_W), .SNAP(SNAP), .MAX_W(MAX_W), .LEN_W(LEN_W)) u_pc (
    .clk(clk), .rst_n(rst_n),
    .exe_take(exe_take), .exe_target(exe_target),
    .dec_take(dec_take), .dec_target(dec_target),
    .issue(issue), .pc_q(req_addr), .len(req_len)
  );

  assign req_valid = issue;

  assert_stream_on_exe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid |=> (req_stream == $past(req_stream) + SEQ_W'(1)));
  assert_drain_needs_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> (inflight_empty && !req_valid));
endmodule

// File: tb/tb_fetch_stream_ctl.sv
module tb_fetch_stream_ctl;
  localparam int AW = 32, SNAP = 64, MAXW = 16, SEQW = 8, LINEW = 16, LENW = 5;

  logic clk = 0, rst_n = 0;
  logic exe_valid = 0, exe_halt = 0, dec_valid = 0, can_issue = 0, inflight_empty = 0;
  logic [AW-1:0] exe_target = '0, dec_target = '0;
  logic req_valid, drained;
  logic [AW-1:0] req_addr;
  logic [LENW-1:0] req_len;
  logic [SEQW-1:0] req_stream, req_pred;
  logic [LINEW-1:0] req_line;

  fetch_stream_ctl dut (.*);

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0;

  // Reference model state: 0 waiting, 1 halted, 2 running
  int m_state;
  logic [AW-1:0] m_pc;
  logic [SEQW-1:0] m_stream, m_pred;
  logic [LINEW-1:0] m_line;

  function automatic int ref_len(logic [AW-1:0] a);
    int room;
    room = SNAP - int'(a % SNAP);
    return (room < MAXW) ? room : MAXW;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance model by the coming edge, then compare everything at the next falling edge
  task automatic cycle();
    bit iss;
    iss = (m_state == 2) && can_issue;
    if (rst_n) begin
      if (exe_valid) begin
        m_stream++; m_pred++; m_pc = exe_target; m_state = exe_halt ? 1 : 2;
      end else if (dec_valid && m_state != 1) begin
        m_pred++; m_pc = dec_target; m_state = 2;
      end else if (iss) begin
        m_pc = m_pc + AW'(ref_len(m_pc));
      end
      if (iss) m_line++;
    end
    @(negedge clk);
    chk("R2 req_valid", req_valid, (m_state == 2) && can_issue);
    chk("R4/R5/R6 req_addr", req_addr, m_pc);
    chk("R3 req_len", req_len, ref_len(m_pc));
    chk("R5 req_stream", req_stream, m_stream);
    chk("R6 req_pred", req_pred, m_pred);
    chk("R9 req_line", req_line, m_line);
    chk("R10 drained", drained, (m_state == 1) && inflight_empty);
  endtask

  task automatic idle_in();
    exe_valid = 0; exe_halt = 0; dec_valid = 0;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_state = 0; m_pc = '0; m_stream = '0; m_pred = '0; m_line = '0;
    can_issue = 1; inflight_empty = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 req_valid", req_valid, 0);
    chk("R1 drained", drained, 0);
    chk("R1 req_addr", req_addr, 0);
    chk("R1 tags", {req_stream, req_pred, req_line}, 0);
    cycle(); // still waiting: no issue (R2)
    // R5 unaligned redirect: 0x3A -> len 6, then 0x40 len 16
    exe_valid = 1; exe_target = 32'h1000_003A; cycle(); idle_in();
    chk("R3 first fetch short", req_len, 6);
    cycle();
    chk("R4 advance to block", req_addr, 32'h1000_0040);
    cycle();
    chk("R4 aligned step", req_addr, 32'h1000_0050);
    // R7 both redirects same cycle
    exe_valid = 1; exe_target = 32'h2000_0004; dec_valid = 1; dec_target = 32'h3000_0000;
    cycle(); idle_in();
    chk("R7 exe wins addr", req_addr, 32'h2000_0004);
    chk("R7 stream", req_stream, 2);
    // R6 decode redirect
    dec_valid = 1; dec_target = 32'h4000_0010; cycle(); idle_in();
    chk("R6 stream unchanged", req_stream, 2);
    // R8 halt, then ignored decode redirect
    exe_valid = 1; exe_halt = 1; exe_target = 32'h0; cycle(); idle_in();
    chk("R8 halted no issue", req_valid, 0);
    chk("R8 drained", drained, 1);
    dec_valid = 1; dec_target = 32'h5000_0000; cycle(); idle_in();
    chk("R8 dec ignored pred", req_pred, m_pred);
    chk("R8 still halted", req_valid, 0);
    inflight_empty = 0; cycle();
    chk("R10 not drained with inflight", drained, 0);
    // Random run
    for (int i = 0; i < 4000; i++) begin
      exe_valid = ($urandom_range(0, 9) == 0);
      exe_halt = ($urandom_range(0, 3) == 0);
      exe_target = $urandom();
      dec_valid = ($urandom_range(0, 7) == 0);
      dec_target = $urandom();
      can_issue = ($urandom_range(0, 3) != 0);
      inflight_empty = $urandom_range(0, 1);
      cycle();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule